// File: doc/BRIEF.md
# SQE Heartbeat Test Checker

This block confirms that an Ethernet transceiver answers every transmitted frame with its signal-quality-error heartbeat. After a transmission ends, the transceiver should raise its collision indication briefly. The block waits for the end-of-transmit event from whichever physical port is selected. It then opens a window that lasts a fixed number of network bit times and watches the collision line of that same port during the window. If the window closes without any collision indication, the block sets a sticky error bit in its interrupt status register. It also pulls the active-low interrupt low, unless software has masked the bit.

Three kinds of port are supported. On the attachment-unit port, the window starts when the data output goes idle, and the returned heartbeat is a burst at roughly 10 MHz on the collision pair. On the general-purpose serial port, the window starts when transmit enable drops, and the collision pin is watched. On the direct-attach port, the heartbeat is never expected, so the check is skipped. The window advances only on a one-cycle bit-time enable, which the rest of the MAC pulses once per 100 ns bit at 10 Mb/s. The host reads the status register to clear it.

Top module: `sqe_heartbeat_monitor`

## Requirements
- R1: After reset, the status register reads 0, the mask register is 0 and `intN` is high.
- R2: With `portSel` = 0 (attachment port), a falling edge of `attachTxActive` opens a window. If `attachColl` is never high while the window is open, status bit 5 reads 1 from the cycle after the clock edge that consumes the 40th `bitTick` pulse, and it is still 0 before that pulse.
- R3: With `portSel` = 1 (serial port), the window starts on a falling edge of `serialTxEn` and watches only `serialColl`. The collision line of the unselected port has no effect.
- R4: A collision indication in any cycle while the window is open cancels the error for that frame, including the cycle of the 40th pulse. A collision indication after the window has closed does not clear an error.
- R5: With `portSel` = 2 or 3 (direct-attach), status bit 5 is never set.
- R6: If the selected transmit signal goes active again before the window expires, the check is abandoned and no error is recorded. This includes the cycle of the 40th pulse.
- R7: `intN` is low exactly when status bit 5 is 1 and mask bit 5 is 0. A one-cycle `maskWe` pulse loads `maskWdata` into the mask register, and `intN` follows on the next cycle.
- R8: A one-cycle `statusRd` pulse clears the status register at that clock edge. If an error is recorded at the same edge, the error bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One-cycle pulse per network bit time |
| portSel | input | 2 | 0 attachment, 1 serial, 2/3 direct-attach |
| attachTxActive | input | 1 | Attachment-port data output active |
| serialTxEn | input | 1 | Serial-port transmit enable |
| attachColl | input | 1 | Collision indication seen on the attachment port |
| serialColl | input | 1 | Collision pin of the serial port |
| maskWe | input | 1 | Mask register write strobe |
| maskWdata | input | 8 | Mask register write data (bit 5 masks the heartbeat error) |
| statusRd | input | 1 | Status register read strobe (clears it) |
| statusData | output | 8 | Interrupt status register, bit 5 = missing heartbeat |
| intN | output | 1 | Active-low interrupt |

## Verification
The bench spaces bit-time pulses irregularly, so a design that counted clock cycles instead of pulses would flag too early or too late. It places a collision and a transmit restart exactly on the 40th pulse, where an off-by-one window would wrongly flag. It also places a collision just after the window, which a window that is too long would absorb. Noise on the unselected port's collision line catches a wrong port multiplexer. Reads that land on the same edge as a new error expose a clear that wins over a set, and a mask toggle with the error pending exposes an interrupt that does not track the mask.

// File: rtl/sqe_pkg.sv
package sqe_pkg;

  typedef enum logic [1:0] {
    PORT_ATTACH = 2'd0,
    PORT_SERIAL = 2'd1,
    PORT_DIRECT = 2'd2,
    PORT_SPARE  = 2'd3
  } port_sel_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } win_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntStep;
    logic setSqeErr;
  } win_ctrl_t;

endpackage

// File: rtl/sqe_datapath.sv
module sqe_datapath
  import sqe_pkg::*;
#(
  parameter int WINDOW_BITS = 40,
  parameter int STATUS_W    = 8,
  parameter int SQE_BIT     = 5,
  localparam int CNT_W      = $clog2(WINDOW_BITS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitTick,
  input  logic [1:0]          portSel,
  input  logic                attachTxActive,
  input  logic                serialTxEn,
  input  logic                attachColl,
  input  logic                serialColl,
  input  logic                maskWe,
  input  logic [STATUS_W-1:0] maskWdata,
  input  logic                statusRd,
  input  win_ctrl_t           ctrl,
  output logic                txFall,
  output logic                txNow,
  output logic                collNow,
  output logic                checkOn,
  output logic                windowDone,
  output logic [CNT_W-1:0]    winCount,
  output logic [STATUS_W-1:0] statusData,
  output logic                intN
);

  localparam int NUM_SRC = 2;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WINDOW_BITS - 1);

  logic [NUM_SRC-1:0] txSrc;
  logic [NUM_SRC-1:0] collSrc;
  logic [NUM_SRC-1:0] prevSrc;
  logic               prevSel;
  logic [STATUS_W-1:0] statusReg;
  logic [STATUS_W-1:0] maskReg;
  logic [STATUS_W-1:0] statusNext;

  assign txSrc   = {serialTxEn, attachTxActive};
  assign collSrc = {serialColl, attachColl};

  // one history flop per end-of-transmit source
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_hist
    always_ff @(posedge clk) begin
      if (!rstN) prevSrc[s] <= 1'b0;
      else       prevSrc[s] <= txSrc[s];
    end
  end

  always_comb begin
    txNow   = 1'b0;
    prevSel = 1'b0;
    collNow = 1'b0;
    checkOn = 1'b0;
    case (port_sel_e'(portSel))
      PORT_ATTACH: begin
        txNow = txSrc[0]; prevSel = prevSrc[0]; collNow = collSrc[0]; checkOn = 1'b1;
      end
      PORT_SERIAL: begin
        txNow = txSrc[1]; prevSel = prevSrc[1]; collNow = collSrc[1]; checkOn = 1'b1;
      end
      default: begin
        checkOn = 1'b0;
      end
    endcase
  end

  assign txFall     = prevSel & ~txNow;
  assign windowDone = bitTick && (winCount == LAST_CNT);

  always_ff @(posedge clk) begin
    if (!rstN)              winCount <= '0;
    else if (ctrl.cntClear) winCount <= '0;
    else if (ctrl.cntStep)  winCount <= winCount + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)       maskReg <= '0;
    else if (maskWe) maskReg <= maskWdata;
  end

  always_comb begin
    statusNext = statusRd ? '0 : statusReg;
    if (ctrl.setSqeErr) statusNext[SQE_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) statusReg <= '0;
    else       statusReg <= statusNext;
  end

  assign statusData = statusReg;
  assign intN       = ~|(statusReg & ~maskReg);

endmodule

// File: rtl/sqe_control.sv
module sqe_control
  import sqe_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitTick,
  input  logic      txFall,
  input  logic      txNow,
  input  logic      collNow,
  input  logic      checkOn,
  input  logic      windowDone,
  output win_ctrl_t ctrl
);

  win_state_e state, stateNext;

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    case (state)
      ST_IDLE: begin
        if (txFall && checkOn) begin
          stateNext     = ST_WAIT;
          ctrl.cntClear = 1'b1;
        end
      end
      ST_WAIT: begin
        if (!checkOn || collNow || txNow) begin
          stateNext = ST_IDLE;
        end else if (windowDone) begin
          stateNext      = ST_IDLE;
          ctrl.setSqeErr = 1'b1;
        end else if (bitTick) begin
          ctrl.cntStep = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/sqe_heartbeat_monitor.sv
module sqe_heartbeat_monitor
  import sqe_pkg::*;
#(
  parameter int WINDOW_BITS = 40,
  parameter int STATUS_W    = 8,
  parameter int SQE_BIT     = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitTick,
  input  logic [1:0]          portSel,
  input  logic                attachTxActive,
  input  logic                serialTxEn,
  input  logic                attachColl,
  input  logic                serialColl,
  input  logic                maskWe,
  input  logic [STATUS_W-1:0] maskWdata,
  input  logic                statusRd,
  output logic [STATUS_W-1:0] statusData,
  output logic                intN
);

  localparam int CNT_W = $clog2(WINDOW_BITS);

  win_ctrl_t        ctrl;
  logic             txFall, txNow, collNow, checkOn, windowDone;
  logic [CNT_W-1:0] winCount;

  sqe_datapath #(
    .WINDOW_BITS(WINDOW_BITS), .STATUS_W(STATUS_W), .SQE_BIT(SQE_BIT)
  ) uDp (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .portSel(portSel),
    .attachTxActive(attachTxActive), .serialTxEn(serialTxEn),
    .attachColl(attachColl), .serialColl(serialColl),
    .maskWe(maskWe), .maskWdata(maskWdata), .statusRd(statusRd),
    .ctrl(ctrl), .txFall(txFall), .txNow(txNow), .collNow(collNow),
    .checkOn(checkOn), .windowDone(windowDone), .winCount(winCount),
    .statusData(statusData), .intN(intN)
  );

  sqe_control uCtl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .txFall(txFall),
    .txNow(txNow), .collNow(collNow), .checkOn(checkOn),
    .windowDone(windowDone), .ctrl(ctrl)
  );

endmodule

// File: rtl/sqe_heartbeat_monitor_props.sv
module sqe_heartbeat_monitor_props #(
  parameter int WINDOW_BITS = 40,
  parameter int STATUS_W    = 8,
  parameter int SQE_BIT     = 5,
  localparam int CNT_W      = $clog2(WINDOW_BITS)
) (
  input logic                clk,
  input logic                rstN,
  input logic                bitTick,
  input logic [1:0]          portSel,
  input logic                statusRd,
  input logic [STATUS_W-1:0] statusData,
  input logic                intN,
  input logic                collNow,
  input logic                txNow,
  input logic                setErr,
  input logic [CNT_W-1:0]    winCount
);

  // R2: the error only appears on a bit-time pulse
  assert_err_on_tick_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusData[SQE_BIT]) |-> $past(bitTick));

  // R2: window counter stays inside the window
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    winCount < CNT_W'(WINDOW_BITS));

  // R5: direct-attach never produces the error
  assert_direct_silent_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusData[SQE_BIT]) |-> !$past(portSel[1]));

  // R4: a collision seen in the last cycle cancels
  assert_coll_cancels_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusData[SQE_BIT]) |-> !$past(collNow));

  // R6: a restarted transmission abandons the check
  assert_restart_abandons_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusData[SQE_BIT]) |-> !$past(txNow));

  // R8: a read with no concurrent error clears everything
  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !setErr) |=> (statusData == '0));

  // R7: the interrupt needs a pending error
  assert_int_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    !intN |-> statusData[SQE_BIT]);

endmodule

bind sqe_heartbeat_monitor sqe_heartbeat_monitor_props #(
  .WINDOW_BITS(WINDOW_BITS), .STATUS_W(STATUS_W), .SQE_BIT(SQE_BIT)
) uProps (
  .clk(clk), .rstN(rstN), .bitTick(bitTick), .portSel(portSel),
  .statusRd(statusRd), .statusData(statusData), .intN(intN),
  .collNow(collNow), .txNow(txNow), .setErr(ctrl.setSqeErr),
  .winCount(winCount)
);

// File: tb/sqe_heartbeat_monitor_test.sv
module sqe_heartbeat_monitor_test;

  localparam int WIN = 40;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitTick = 1'b0;
  logic [1:0] portSel = 2'd0;
  logic       attachTxActive = 1'b0, serialTxEn = 1'b0;
  logic       attachColl = 1'b0, serialColl = 1'b0;
  logic       maskWe = 1'b0;
  logic [7:0] maskWdata = 8'h00;
  logic       statusRd = 1'b0;
  wire  [7:0] statusData;
  wire        intN;

  int  checks = 0;
  int  errors = 0;
  bit  maskBit = 1'b0;

  always #2 clk = ~clk;

  sqe_heartbeat_monitor uut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .portSel(portSel),
    .attachTxActive(attachTxActive), .serialTxEn(serialTxEn),
    .attachColl(attachColl), .serialColl(serialColl),
    .maskWe(maskWe), .maskWdata(maskWdata), .statusRd(statusRd),
    .statusData(statusData), .intN(intN)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setTx(bit v);
    attachTxActive = v;
    serialTxEn     = v;
  endtask

  task automatic setColl(int port, bit v);
    if (port == 1) serialColl = v;
    else           attachColl = v;
  endtask

  function automatic bit expectErr(int port, int collK, int restK);
    if (port >= 2) return 1'b0;
    if (collK >= 1 && collK <= WIN) return 1'b0;
    if (restK >= 1 && restK <= WIN) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit expIntN(bit st, bit m);
    return !(st && !m);
  endfunction

  function automatic string tagFor(int port, int collK, int restK);
    if (port >= 2) return "R5";
    if (collK >= 1) return "R4";
    if (restK >= 1 && restK <= WIN) return "R6";
    if (port == 1) return "R3";
    return "R2";
  endfunction

  task automatic writeMask(bit v);
    maskWe = 1'b1;
    maskWdata = v ? 8'h20 : 8'h00;
    @(negedge clk);
    maskWe = 1'b0;
    maskBit = v;
    @(negedge clk);
    check(intN == expIntN(statusData[5], maskBit), "R7 mask write", intN,
          expIntN(statusData[5], maskBit));
  endtask

  task automatic readClear();
    statusRd = 1'b1;
    @(negedge clk);
    statusRd = 1'b0;
    check(statusData == 8'h00, "R8 read clears", statusData, 0);
    check(intN == 1'b1, "R8 intN after read", intN, 1);
  endtask

  // collK: pulse index carrying a collision (0 none, >WIN after window)
  // restK: pulse index where transmission restarts (>WIN none)
  task automatic frame(int port, int collK, int restK, bit otherColl, bit rdOnLast);
    bit    exp;
    string tag;
    exp = expectErr(port, collK, restK);
    tag = tagFor(port, collK, restK);
    portSel = port[1:0];
    bitTick = 1'b0;
    setTx(1'b1);
    repeat (3) @(negedge clk);
    setTx(1'b0);
    @(negedge clk);
    if (port == 1) attachColl = otherColl;
    else if (port == 0) serialColl = otherColl;
    for (int k = 1; k <= WIN; k++) begin
      int gap;
      gap = $urandom % 3;
      repeat (gap) @(negedge clk);
      if (k == WIN && exp)
        check(statusData[5] == 1'b0, "R2 no early flag", statusData[5], 0);
      bitTick = 1'b1;
      if (k == collK) setColl(port, 1'b1);
      if (k == restK) setTx(1'b1);
      if (k == WIN && rdOnLast) statusRd = 1'b1;
      @(negedge clk);
      bitTick  = 1'b0;
      statusRd = 1'b0;
      setColl(port, 1'b0);
    end
    if (collK > WIN) begin
      setColl(port, 1'b1);
      @(negedge clk);
      setColl(port, 1'b0);
    end
    attachColl = 1'b0;
    serialColl = 1'b0;
    check(statusData[5] == exp, rdOnLast ? "R8 set wins over read" : tag,
          statusData[5], exp);
    check(intN == expIntN(exp, maskBit), "R7 intN", intN, expIntN(exp, maskBit));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(statusData == 8'h00, "R1 status reset", statusData, 0);
    check(intN == 1'b1, "R1 intN reset", intN, 1);

    frame(0, 0, 99, 1'b0, 1'b0); readClear();
    frame(1, 0, 99, 1'b1, 1'b0); readClear();
    frame(0, 0, 99, 1'b1, 1'b0); readClear();
    frame(0, WIN, 99, 1'b0, 1'b0); readClear();
    frame(0, WIN + 1, 99, 1'b0, 1'b0); readClear();
    frame(1, 15, 99, 1'b0, 1'b0); readClear();
    frame(2, 0, 99, 1'b0, 1'b0); readClear();
    frame(3, 0, 99, 1'b0, 1'b0); readClear();
    frame(0, 0, WIN, 1'b0, 1'b0); readClear();
    frame(1, 0, 10, 1'b0, 1'b0); readClear();
    frame(0, 0, 99, 1'b0, 1'b1); readClear();

    // masked error, then unmask while pending
    writeMask(1'b1);
    frame(1, 0, 99, 1'b0, 1'b0);
    writeMask(1'b0);
    check(intN == 1'b0, "R7 unmask raises intN", intN, 0);
    readClear();

    for (int i = 0; i < 60; i++) begin
      int  port, collK, restK;
      port  = $urandom % 4;
      collK = (($urandom % 3) == 0) ? 0 : int'($urandom % 46);
      restK = (($urandom % 4) == 0) ? 1 + int'($urandom % 44) : 99;
      if (($urandom % 8) == 0) writeMask(($urandom % 2) == 1);
      frame(port, collK, restK, ($urandom % 2) == 1, ($urandom % 6) == 0);
      readClear();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule